// File: doc/BRIEF.md
# Memory ECC Guard with Check-Code Injection

This block protects a 64-bit memory data path with an extended Hamming SEC-DED code. On every write, it computes an 8-bit check code and hands the data and code to the memory side together. On every read, it checks the returned data against its code. It corrects any single-bit error and flags it. It only flags a double-bit error.

Two 8-bit injection masks let test logic exercise the error checker on purpose.

- The write mask is XORed into every code computed from then on, so bad codes are planted in memory.
- The read mask is XORed into the code on the processor read return, before the check runs.

Both masks reset to zero, which means no injection. A check-enable bit, clear after reset, gates detection and correction. While it is clear, read data passes through raw and no flag is raised.

Configuration writes use a select field: 0 loads the write mask, 1 loads the read mask, 2 loads the enable from `cfgData[0]`, and 3 does nothing.

Top module: `ecc_inject_guard`

## Requirements
- R1: A write accepted with `wrValid` appears one cycle later on `memWrValid`/`memWrData`. `memWrCode` carries the code described next. The code is built by placing data bit k at the k-th non-power-of-two position of 1..71, counting upward. Check bit b (b = 0..6) is the XOR of the data bits whose position has bit b set. Code bit 7 is the XOR of all 64 data bits and code bits 6:0.
- R2: The write mask resets to zero. While it is non-zero, the stored code is the R1 code XORed bit by bit with the mask. A mask of zero leaves the code unchanged.
- R3: A write-mask load takes effect for writes accepted in the following cycle and later. A write accepted in the same cycle as the load uses the previous mask.
- R4: The read mask resets to zero. `respCode` is `rdCode` XORed with the read mask, and this masked code is the one that is checked.
- R5: The check enable is clear after reset. While it is clear, `sbErr` and `dbErr` stay low and `respData` equals `rdData`.
- R6: With checking on, a single flipped data bit raises `sbErr` and is corrected in `respData`.
- R7: With checking on, a single flipped code bit, including bit 7, raises `sbErr` and leaves `respData` equal to `rdData`.
- R8: With checking on, two flipped bits raise `dbErr` and leave `respData` uncorrected. A non-zero syndrome with even overall parity counts as two flipped bits.
- R9: A read accepted with `rdValid` yields `respValid` exactly one cycle later. With checking on, a clean word raises no flag.
- R10: `sbErr` and `dbErr` are never high together and are only high alongside `respValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 write mask, 1 read mask, 2 enable |
| cfgData | input | 8 | Configuration value |
| wrValid | input | 1 | Write data valid |
| wrData | input | 64 | Write data |
| memWrValid | output | 1 | Write to memory valid |
| memWrData | output | 64 | Data to memory |
| memWrCode | output | 8 | Check code to memory, write mask applied |
| rdValid | input | 1 | Read return from memory valid |
| rdData | input | 64 | Data read from memory |
| rdCode | input | 8 | Code read from memory |
| respValid | output | 1 | Processor read response valid |
| respData | output | 64 | Read data, corrected when checking is on |
| respCode | output | 8 | Code delivered with the read, read mask applied |
| sbErr | output | 1 | Corrected single-bit error |
| dbErr | output | 1 | Uncorrectable double-bit error |

## Verification
The assertions take for granted that `wrValid` and `rdValid` are low while reset is held. Otherwise the one-cycle latency checks would compare against stale pre-reset strobes. They also assume that the enable changes only through select value 2, which the checker mirrors from the configuration ports. The stimulus drives every input low during reset. It changes inputs only on falling edges, one configuration write at a time, so the checker's mirror of the enable always matches the design's view of it.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

  parameter int unsigned DATA_W = 64;

  // smallest p with 2^p >= DATA_W + p + 1
  function automatic int unsigned chkBits(int unsigned n);
    int unsigned p;
    p = 0;
    while ((1 << p) < (n + p + 1)) p++;
    return p;
  endfunction

  localparam int unsigned CHK_W  = chkBits(DATA_W);
  localparam int unsigned CODE_W = CHK_W + 1;
  localparam int unsigned POS_N  = 1 << CHK_W;

  typedef struct packed {
    logic [CODE_W-1:0] wrMask;
    logic [CODE_W-1:0] rdMask;
    logic              chkEn;
    logic              wrGo;
    logic              rdGo;
  } ctrl_t;

  // codeword position of data bit idx: idx-th non-power-of-two position
  function automatic logic [CHK_W-1:0] dataPos(int unsigned idx);
    int unsigned seen;
    logic [CHK_W-1:0] res;
    seen = 0;
    res  = '0;
    for (int unsigned p = 1; p < POS_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == idx) res = p[CHK_W-1:0];
        seen++;
      end
    end
    return res;
  endfunction

  function automatic logic [CODE_W-1:0] encode(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (d[i]) c = c ^ dataPos(i);
    end
    return {(^d) ^ (^c), c};
  endfunction

endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [CODE_W-1:0] cfgData,
  input  logic              wrValid,
  input  logic              rdValid,
  output ctrl_t             ctl
);

  localparam logic [1:0] SEL_WMASK = 2'd0;
  localparam logic [1:0] SEL_RMASK = 2'd1;
  localparam logic [1:0] SEL_EN    = 2'd2;

  logic [CODE_W-1:0] wrMaskQ;
  logic [CODE_W-1:0] rdMaskQ;
  logic              enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrMaskQ <= '0;
      rdMaskQ <= '0;
      enQ     <= 1'b0;
    end else if (cfgWrEn) begin
      case (cfgSel)
        SEL_WMASK: wrMaskQ <= cfgData;
        SEL_RMASK: rdMaskQ <= cfgData;
        SEL_EN:    enQ     <= cfgData[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    ctl.wrMask = wrMaskQ;
    ctl.rdMask = rdMaskQ;
    ctl.chkEn  = enQ;
    ctl.wrGo   = wrValid;
    ctl.rdGo   = rdValid;
  end

endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CODE_W-1:0] rdCode,
  output logic              memWrValid,
  output logic [DATA_W-1:0] memWrData,
  output logic [CODE_W-1:0] memWrCode,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic [CODE_W-1:0] respCode,
  output logic              sbErr,
  output logic              dbErr
);

  // write side
  logic [CODE_W-1:0] wrCode;
  assign wrCode = encode(wrData) ^ ctl.wrMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrValid <= 1'b0;
      memWrData  <= '0;
      memWrCode  <= '0;
    end else begin
      memWrValid <= ctl.wrGo;
      if (ctl.wrGo) begin
        memWrData <= wrData;
        memWrCode <= wrCode;
      end
    end
  end

  // read side
  logic [CODE_W-1:0] codeIn;
  logic [CODE_W-1:0] recalc;
  logic [CHK_W-1:0]  syn;
  logic              oddPar;
  logic [DATA_W-1:0] flipHit;
  logic              hitData;
  logic              hitChk;
  logic              sbNow;
  logic              dbNow;
  logic [DATA_W-1:0] fixData;

  assign codeIn = rdCode ^ ctl.rdMask;
  assign recalc = encode(rdData);
  assign syn    = recalc[CHK_W-1:0] ^ codeIn[CHK_W-1:0];
  assign oddPar = (^rdData) ^ (^codeIn);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_flip
    localparam logic [CHK_W-1:0] POS = dataPos(gi);
    assign flipHit[gi] = (syn == POS);
  end

  assign hitData = |flipHit;
  assign hitChk  = $onehot(syn);

  always_comb begin
    sbNow   = 1'b0;
    dbNow   = 1'b0;
    fixData = rdData;
    if (ctl.chkEn) begin
      if (oddPar) begin
        if (syn == '0 || hitChk) begin
          sbNow = 1'b1;
        end else if (hitData) begin
          sbNow   = 1'b1;
          fixData = rdData ^ flipHit;
        end else begin
          dbNow = 1'b1;
        end
      end else if (syn != '0) begin
        dbNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
      respCode  <= '0;
      sbErr     <= 1'b0;
      dbErr     <= 1'b0;
    end else begin
      respValid <= ctl.rdGo;
      sbErr     <= ctl.rdGo & sbNow;
      dbErr     <= ctl.rdGo & dbNow;
      if (ctl.rdGo) begin
        respData <= fixData;
        respCode <= codeIn;
      end
    end
  end

endmodule

// File: rtl/ecc_inject_guard.sv
module ecc_inject_guard
  import ecc_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [CODE_W-1:0] cfgData,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              memWrValid,
  output logic [DATA_W-1:0] memWrData,
  output logic [CODE_W-1:0] memWrCode,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CODE_W-1:0] rdCode,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic [CODE_W-1:0] respCode,
  output logic              sbErr,
  output logic              dbErr
);

  ctrl_t ctl;

  ecc_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .wrValid (wrValid),
    .rdValid (rdValid),
    .ctl     (ctl)
  );

  ecc_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrData     (wrData),
    .rdData     (rdData),
    .rdCode     (rdCode),
    .memWrValid (memWrValid),
    .memWrData  (memWrData),
    .memWrCode  (memWrCode),
    .respValid  (respValid),
    .respData   (respData),
    .respCode   (respCode),
    .sbErr      (sbErr),
    .dbErr      (dbErr)
  );

endmodule

// File: rtl/ecc_guard_chk.sv
module ecc_guard_chk
  import ecc_guard_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [1:0]        cfgSel,
  input logic [CODE_W-1:0] cfgData,
  input logic              wrValid,
  input logic [DATA_W-1:0] wrData,
  input logic              memWrValid,
  input logic [DATA_W-1:0] memWrData,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              respValid,
  input logic [DATA_W-1:0] respData,
  input logic              sbErr,
  input logic              dbErr
);

  logic enShadow;
  always_ff @(posedge clk) begin
    if (!rstN) enShadow <= 1'b0;
    else if (cfgWrEn && cfgSel == 2'd2) enShadow <= cfgData[0];
  end

  p_wr_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid == $past(wrValid));

  p_wr_data_r1: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> memWrData == $past(wrData));

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    respValid == $past(rdValid));

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(sbErr && dbErr));

  p_flag_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sbErr || dbErr) |-> respValid);

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !$past(enShadow)) |-> (!sbErr && !dbErr && respData == $past(rdData)));

  p_db_raw_r8: assert property (@(posedge clk) disable iff (!rstN)
    dbErr |-> respData == $past(rdData));

endmodule

bind ecc_inject_guard ecc_guard_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgSel     (cfgSel),
  .cfgData    (cfgData),
  .wrValid    (wrValid),
  .wrData     (wrData),
  .memWrValid (memWrValid),
  .memWrData  (memWrData),
  .rdValid    (rdValid),
  .rdData     (rdData),
  .respValid  (respValid),
  .respData   (respData),
  .sbErr      (sbErr),
  .dbErr      (dbErr)
);

// File: tb/test_ecc_inject_guard.sv
module test_ecc_inject_guard;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgSel;
  logic [7:0]  cfgData;
  logic        wrValid;
  logic [63:0] wrData;
  logic        memWrValid;
  logic [63:0] memWrData;
  logic [7:0]  memWrCode;
  logic        rdValid;
  logic [63:0] rdData;
  logic [7:0]  rdCode;
  logic        respValid;
  logic [63:0] respData;
  logic [7:0]  respCode;
  logic        sbErr;
  logic        dbErr;

  int nRun  = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  ecc_inject_guard i_ecc_inject_guard (.*);

  // reference code, built from R1 by laying out a 72-bit codeword
  function automatic logic [7:0] refCode(logic [63:0] d);
    logic [71:0] cw;
    logic [6:0]  c;
    int k;
    cw = '0;
    k  = 0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[k];
        k++;
      end
    end
    for (int b = 0; b < 7; b++) begin
      c[b] = 1'b0;
      for (int pos = 1; pos < 72; pos++)
        if (((pos >> b) & 1) == 1) c[b] = c[b] ^ cw[pos];
    end
    return {(^d) ^ (^c), c};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doWrite(input string tag, input logic [63:0] d, input logic [7:0] expCode);
    @(negedge clk);
    wrValid = 1'b1; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    check({tag, " valid"}, {63'd0, memWrValid}, 64'd1);
    check({tag, " data"}, memWrData, d);
    check({tag, " code"}, {56'd0, memWrCode}, {56'd0, expCode});
  endtask

  task automatic doRead(input string tag, input logic [63:0] d, input logic [7:0] code,
                        input logic [63:0] expData, input logic [7:0] expCode,
                        input logic expSb, input logic expDb);
    @(negedge clk);
    rdValid = 1'b1; rdData = d; rdCode = code;
    @(negedge clk);
    rdValid = 1'b0;
    check({tag, " R9 valid"}, {63'd0, respValid}, 64'd1);
    check({tag, " data"}, respData, expData);
    check({tag, " code"}, {56'd0, respCode}, {56'd0, expCode});
    check({tag, " sbErr"}, {63'd0, sbErr}, {63'd0, expSb});
    check({tag, " dbErr"}, {63'd0, dbErr}, {63'd0, expDb});
  endtask

  task automatic testReset();
    check("R9 reset respValid", {63'd0, respValid}, 64'd0);
    check("R1 reset memWrValid", {63'd0, memWrValid}, 64'd0);
    check("R10 reset flags", {62'd0, sbErr, dbErr}, 64'd0);
  endtask

  task automatic testEncode();
    doWrite("R1 zero", 64'd0, refCode(64'd0));
    doWrite("R1 ones", '1, refCode('1));
    doWrite("R2 no mask", 64'h0123_4567_89AB_CDEF, refCode(64'h0123_4567_89AB_CDEF));
    doWrite("R1 bit63", 64'h8000_0000_0000_0000, refCode(64'h8000_0000_0000_0000));
  endtask

  task automatic testEnableOff();
    logic [63:0] d;
    d = 64'hDEAD_BEEF_0000_FFFF;
    doRead("R5 off single flip", d ^ 64'h10, refCode(d), d ^ 64'h10, refCode(d), 1'b0, 1'b0);
    doRead("R5 off double flip", d ^ 64'h3, refCode(d), d ^ 64'h3, refCode(d), 1'b0, 1'b0);
  endtask

  task automatic testClean();
    logic [63:0] d;
    d = 64'hA5A5_5A5A_F0F0_0F0F;
    doRead("R9 clean", d, refCode(d), d, refCode(d), 1'b0, 1'b0);
  endtask

  task automatic testSingleData();
    logic [63:0] d;
    d = 64'h1357_9BDF_2468_ACE0;
    foreach (d[i]) begin
      if (i == 0 || i == 37 || i == 63) begin
        doRead("R6 data flip", d ^ (64'd1 << i), refCode(d), d, refCode(d), 1'b1, 1'b0);
      end
    end
  endtask

  task automatic testSingleCode();
    logic [63:0] d;
    d = 64'h0F0F_1234_8765_FFFF;
    doRead("R7 check bit2", d, refCode(d) ^ 8'h04, d, refCode(d) ^ 8'h04, 1'b1, 1'b0);
    doRead("R7 parity bit7", d, refCode(d) ^ 8'h80, d, refCode(d) ^ 8'h80, 1'b1, 1'b0);
  endtask

  task automatic testDouble();
    logic [63:0] d;
    d = 64'hCAFE_F00D_0BAD_BEEF;
    doRead("R8 two data bits", d ^ 64'h0000_0100_0000_0004, refCode(d),
           d ^ 64'h0000_0100_0000_0004, refCode(d), 1'b0, 1'b1);
    doRead("R8 data and code", d ^ 64'h2, refCode(d) ^ 8'h01,
           d ^ 64'h2, refCode(d) ^ 8'h01, 1'b0, 1'b1);
  endtask

  task automatic testWriteMask();
    logic [63:0] d;
    d = 64'h1111_2222_3333_4444;
    cfgWrite(2'd0, 8'h5A);
    doWrite("R2 mask 5A", d, refCode(d) ^ 8'h5A);
    doRead("R2 masked readback", memWrData, memWrCode, d, refCode(d) ^ 8'h5A, 1'b0, 1'b1);
    cfgWrite(2'd0, 8'h01);
    doWrite("R2 mask 01", d, refCode(d) ^ 8'h01);
    doRead("R2 single readback", memWrData, memWrCode, d, refCode(d) ^ 8'h01, 1'b1, 1'b0);
    cfgWrite(2'd0, 8'h00);
    doWrite("R2 mask cleared", d, refCode(d));
  endtask

  task automatic testMaskTiming();
    logic [63:0] d1;
    logic [63:0] d2;
    d1 = 64'h0000_0000_0000_00FF;
    d2 = 64'hFF00_0000_0000_0000;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 2'd0; cfgData = 8'h0F;
    wrValid = 1'b1; wrData = d1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    wrData  = d2;
    check("R3 same-cycle old mask", {56'd0, memWrCode}, {56'd0, refCode(d1)});
    @(negedge clk);
    wrValid = 1'b0;
    check("R3 next-cycle new mask", {56'd0, memWrCode}, {56'd0, refCode(d2) ^ 8'h0F});
    cfgWrite(2'd0, 8'h00);
  endtask

  task automatic testReadMask();
    logic [63:0] d;
    d = 64'h7777_0000_9999_3333;
    cfgWrite(2'd1, 8'h80);
    doRead("R4 read mask parity", d, refCode(d), d, refCode(d) ^ 8'h80, 1'b1, 1'b0);
    cfgWrite(2'd1, 8'h03);
    doRead("R4 read mask double", d, refCode(d), d, refCode(d) ^ 8'h03, 1'b0, 1'b1);
    cfgWrite(2'd1, 8'h00);
    doRead("R4 read mask cleared", d, refCode(d), d, refCode(d), 1'b0, 1'b0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgSel = '0; cfgData = '0;
    wrValid = 1'b0; wrData = '0; rdValid = 1'b0; rdData = '0; rdCode = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEncode();
    testEnableOff();
    cfgWrite(2'd2, 8'h01);
    testClean();
    testSingleData();
    testSingleCode();
    testDouble();
    testWriteMask();
    testMaskTiming();
    testReadMask();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule